// File: doc/BRIEF.md
# Three-Code Sequential Combination Lock

This block is a lock that opens only after a user keys in three 4-bit values in the correct order. Three stored codes feed a one-hot multiplexer. The multiplexer picks the code that the current step expects. A combinational equality comparator checks each keyed value against that code, and a small controller moves forward on every strobed entry that matches.

The controller is output-encoded. Its state register is its output word: one lock bit followed by the one-hot multiplexer select. An entry step therefore drives the multiplexer straight from flip-flops. The open state drives the lock bit directly.

The error state is the all-zero word. Each state flip-flop has a synchronous preset and clear. The start input presets the first-step bit and clears the others. A mismatch, or a word with no bit set, clears them all.

A user holds `start_i` high to arm the lock. The user then presents each value on `value_i` together with a one-cycle `new_i` strobe. Once the lock is open or has failed, it stays that way until start is asserted again. Loading and storing the codes is done elsewhere.

Top module: `seq_combo_lock`

## Requirements
- R1: In the cycle after `start_i` is sampled high, from any state, `sel_o` is `100` and `lock_open_o` is 0 (the first entry step).
- R2: The state word `{lock_open_o, sel_o}` always has at most one bit set. `lock_open_o` is 1 only in the open state.
- R3: `sel_o` is one-hot, and its bit positions map to steps as follows:
  - `100` (bit 2) picks the first code.
  - `010` picks the second code.
  - `001` picks the third code.
  - Code k (k = 0, 1, 2) sits in bits [4k+3:4k] of `codes_i`.
- R4: A `new_i` strobe during an entry step whose `value_i` equals the selected code moves the select one step right. A matching strobe on the third step gives `sel_o = 000` and `lock_open_o = 1` on the next cycle.
- R5: A `new_i` strobe during an entry step whose `value_i` differs from the selected code gives the error word (`sel_o = 000`, `lock_open_o = 0`) on the next cycle.
- R6: In a cycle without `new_i` and without `start_i`, the state word is held whatever `value_i` carries.
- R7: The open state and the error state persist until start, whatever values or strobes arrive. Strobes during these states are ignored.
- R8: When `start_i` and `new_i` are high in the same cycle, start wins and the next state is the first entry step.
- R9: The order of entry matters. A value equal to a code other than the one the current step selects counts as a mismatch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| start_i | input | 1 | Synchronous start; arms the lock at the first entry step |
| new_i | input | 1 | One-cycle strobe marking a keyed value |
| value_i | input | 4 | Keyed value |
| codes_i | input | 12 | Three stored codes; code k in bits [4k+3:4k] |
| lock_open_o | output | 1 | Lock state, 1 = open |
| sel_o | output | 3 | One-hot code select (the controller's step bits) |

## Verification
The bound checker enforces the following on every cycle after the first start:
- the state word is legal;
- start lands on the first step;
- quiet cycles hold the state;
- a match rotates the state one place, and a mismatch clears it;
- the open and error words are terminal;
- the lock rises only after a matching strobe.

Some behaviours only the bench scenarios can show. These are:
- that the right code is picked at each step, including order violations and repeated code values;
- that start beats a simultaneous strobe;
- a complete open sequence with idle gaps between entries.

These scenarios are compared every clock against a behavioural step counter.

// File: rtl/combo_lock_pkg.sv
package combo_lock_pkg;
  localparam int VAL_W_DEF = 4;
  localparam int STEPS_DEF = 3;

  // select bit that stands for entry step k (first step uses the top bit)
  function automatic int sel_bit(input int steps, input int k);
    return steps - 1 - k;
  endfunction
endpackage

// File: rtl/code_sel_mux.sv
module code_sel_mux
  import combo_lock_pkg::*;
#(
  parameter int VAL_W = VAL_W_DEF,
  parameter int STEPS = STEPS_DEF
) (
  input  logic [STEPS-1:0]       sel_i,
  input  logic [STEPS*VAL_W-1:0] codes_i,
  output logic [VAL_W-1:0]       expect_o
);
  logic [VAL_W-1:0] term [STEPS];

  for (genvar k = 0; k < STEPS; k++) begin : g_term
    assign term[k] = {VAL_W{sel_i[sel_bit(STEPS, k)]}} & codes_i[k*VAL_W +: VAL_W];
  end

  always_comb begin
    expect_o = '0;
    for (int k = 0; k < STEPS; k++) expect_o = expect_o | term[k];
  end
endmodule

// File: rtl/value_cmp.sv
module value_cmp
  import combo_lock_pkg::*;
#(
  parameter int VAL_W = VAL_W_DEF
) (
  input  logic [VAL_W-1:0] a_i,
  input  logic [VAL_W-1:0] b_i,
  output logic             eq_o
);
  function automatic logic same(input logic [VAL_W-1:0] x, input logic [VAL_W-1:0] y);
    return ~|(x ^ y);
  endfunction

  assign eq_o = same(a_i, b_i);
endmodule

// File: rtl/lock_ctrl.sv
module lock_ctrl
  import combo_lock_pkg::*;
#(
  parameter int STEPS = STEPS_DEF
) (
  input  logic         clk_i,
  input  logic         start_i,
  input  logic         new_i,
  input  logic         eq_i,
  output logic [STEPS:0] state_o,
  output logic         hit_o,
  output logic         miss_o
);
  localparam int SW    = STEPS + 1;
  localparam int LOCK  = STEPS;
  localparam int FIRST = STEPS - 1;

  logic [SW-1:0] state_q;
  logic [SW-1:0] d_w;
  logic          in_entry_w;
  logic          is_zero_w;
  logic          clr_w;

  assign in_entry_w = |state_q[STEPS-1:0];
  assign is_zero_w  = ~|state_q;
  assign hit_o      = new_i & eq_i & in_entry_w;
  assign miss_o     = new_i & ~eq_i & in_entry_w;
  assign clr_w      = miss_o | is_zero_w;

  // next-state terms: each bit takes the token from its left neighbour on a match
  assign d_w[FIRST] = state_q[FIRST] & ~new_i;
  for (genvar j = 0; j < FIRST; j++) begin : g_step
    assign d_w[j] = (state_q[j+1] & new_i & eq_i) | (state_q[j] & ~new_i);
  end
  assign d_w[LOCK] = (state_q[0] & new_i & eq_i) | state_q[LOCK];

  // per-bit flip-flop with synchronous preset and clear
  for (genvar i = 0; i < SW; i++) begin : g_ff
    logic pre_w, clr_bit_w;
    if (i == FIRST) begin : g_first
      assign pre_w     = start_i;
      assign clr_bit_w = ~start_i & clr_w;
    end else begin : g_other
      assign pre_w     = 1'b0;
      assign clr_bit_w = start_i | clr_w;
    end
    always_ff @(posedge clk_i) begin
      if (pre_w)          state_q[i] <= 1'b1;
      else if (clr_bit_w) state_q[i] <= 1'b0;
      else                state_q[i] <= d_w[i];
    end
  end

  assign state_o = state_q;
endmodule

// File: rtl/seq_combo_lock.sv
module seq_combo_lock
  import combo_lock_pkg::*;
#(
  parameter int VAL_W = VAL_W_DEF,
  parameter int STEPS = STEPS_DEF
) (
  input  logic                   clk_i,
  input  logic                   start_i,
  input  logic                   new_i,
  input  logic [VAL_W-1:0]       value_i,
  input  logic [STEPS*VAL_W-1:0] codes_i,
  output logic                   lock_open_o,
  output logic [STEPS-1:0]       sel_o
);
  logic [STEPS:0]   state_w;
  logic [VAL_W-1:0] expect_w;
  logic             eq_w;
  logic             hit_w;
  logic             miss_w;

  code_sel_mux #(.VAL_W(VAL_W), .STEPS(STEPS)) u_mux (
    .sel_i   (state_w[STEPS-1:0]),
    .codes_i (codes_i),
    .expect_o(expect_w)
  );

  value_cmp #(.VAL_W(VAL_W)) u_cmp (
    .a_i (value_i),
    .b_i (expect_w),
    .eq_o(eq_w)
  );

  lock_ctrl #(.STEPS(STEPS)) u_ctrl (
    .clk_i  (clk_i),
    .start_i(start_i),
    .new_i  (new_i),
    .eq_i   (eq_w),
    .state_o(state_w),
    .hit_o  (hit_w),
    .miss_o (miss_w)
  );

  assign lock_open_o = state_w[STEPS];
  assign sel_o       = state_w[STEPS-1:0];
endmodule

// File: rtl/lock_chk.sv
module lock_chk #(
  parameter int STEPS = 3
) (
  input logic           clk_i,
  input logic           start_i,
  input logic           new_i,
  input logic [STEPS:0] state_i,
  input logic           hit_i,
  input logic           miss_i,
  input logic           lock_open_i
);
  logic armed = 1'b0;
  logic live  = 1'b0;
  always_ff @(posedge clk_i) begin
    if (start_i) armed <= 1'b1;
    live <= armed | start_i;
  end

  a_r1_start_first: assert property (@(posedge clk_i) disable iff (!armed)
    start_i |=> (state_i == (1 << (STEPS-1))));

  a_r2_legal_word: assert property (@(posedge clk_i) disable iff (!live)
    $countones(state_i) <= 1);

  a_r4_match_rotates: assert property (@(posedge clk_i) disable iff (!armed || start_i)
    hit_i |=> state_i == {$past(state_i[0]), $past(state_i[STEPS:1])});

  a_r5_miss_clears: assert property (@(posedge clk_i) disable iff (!armed || start_i)
    miss_i |=> state_i == '0);

  a_r6_quiet_hold: assert property (@(posedge clk_i) disable iff (!armed || start_i)
    !new_i |=> $stable(state_i));

  a_r7_open_stays: assert property (@(posedge clk_i) disable iff (!armed || start_i)
    lock_open_i |=> lock_open_i);

  a_r7_error_stays: assert property (@(posedge clk_i) disable iff (!armed || start_i)
    (state_i == '0) |=> (state_i == '0));

  a_r4_open_needs_hit: assert property (@(posedge clk_i) disable iff (!live)
    $rose(lock_open_i) |-> $past(hit_i));
endmodule

bind seq_combo_lock lock_chk #(.STEPS(STEPS)) u_chk (
  .clk_i      (clk_i),
  .start_i    (start_i),
  .new_i      (new_i),
  .state_i    (state_w),
  .hit_i      (hit_w),
  .miss_i     (miss_w),
  .lock_open_i(lock_open_o)
);

// File: tb/sim_seq_combo_lock.sv
module sim_seq_combo_lock;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        start_i = 1'b1;
  logic        new_i = 1'b0;
  logic [3:0]  value_i = '0;
  logic [11:0] codes_i = '0;
  logic        lock_open_o;
  logic [2:0]  sel_o;

  int checks = 0;
  int bad = 0;
  string req = "R1";
  bit   started = 0;
  int   mstep = 0;   // 0..2 entry steps, 3 open, 4 error
  bit   done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  seq_combo_lock u0 (
    .clk_i(clk), .start_i(start_i), .new_i(new_i), .value_i(value_i),
    .codes_i(codes_i), .lock_open_o(lock_open_o), .sel_o(sel_o)
  );

  function automatic logic [3:0] code_of(int k);
    return codes_i[k*4 +: 4];
  endfunction

  // behavioural reference
  always @(posedge clk) begin
    if (start_i) begin
      mstep = 0;
      started = 1;
    end else if (started && new_i && mstep < 3) begin
      if (value_i == code_of(mstep)) mstep = mstep + 1;
      else mstep = 4;
    end
  end

  always @(negedge clk) begin
    if (started && !done) begin
      logic [2:0] es;
      logic el;
      es = (mstep < 3) ? 3'(1 << (2 - mstep)) : 3'b000;
      el = (mstep == 3);
      checks++;
      if (sel_o !== es || lock_open_o !== el) begin
        bad++;
        $display("FAIL %s sel=%b exp=%b lock=%b exp=%b", req, sel_o, es, lock_open_o, el);
      end
      if (lock_open_o && sel_o != 0) begin
        checks++; bad++;
        $display("FAIL R2 word=%b%b exp=at most one bit", lock_open_o, sel_o);
      end
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic key(logic [3:0] v);
    @(negedge clk);
    value_i = v;
    new_i = 1'b1;
    @(negedge clk);
    new_i = 1'b0;
    value_i = 4'hF ^ v;
  endtask

  task automatic arm();
    @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=timeout exp=finish");
    done = 1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    codes_i = {4'h9, 4'h3, 4'h7};   // third, second, first
    req = "R1";
    idle(2);
    start_i = 1'b0;
    idle(2);
    req = "R3";
    key(4'h7); idle(1);
    req = "R6";
    value_i = 4'h3; idle(3);
    req = "R4";
    key(4'h3); key(4'h9); idle(2);
    req = "R7";
    key(4'h1); key(4'h0); key(4'h7); idle(2);
    req = "R1";
    arm(); idle(1);
    req = "R5";
    key(4'h7); key(4'h5); idle(1);
    req = "R7";
    key(4'h3); key(4'h9); key(4'h0); idle(2);
    req = "R1";
    arm();
    req = "R9";
    key(4'h3); idle(1);
    req = "R9";
    arm(); key(4'h7); key(4'h9); idle(1);
    req = "R8";
    arm(); key(4'h7);
    @(negedge clk); start_i = 1'b1; new_i = 1'b1; value_i = 4'h3;
    @(negedge clk); start_i = 1'b0; new_i = 1'b0;
    idle(2);
    req = "R5";
    key(4'hE); idle(1);
    req = "R4";
    codes_i = {4'h0, 4'h0, 4'h0};
    arm(); key(4'h0); key(4'h0); key(4'h0); idle(2);
    req = "R7";
    key(4'h5); idle(2);
    req = "R5";
    codes_i = {4'hA, 4'hB, 4'hC};
    arm(); key(4'hC); key(4'hB); key(4'hB); idle(2);
    done = 1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule